// File: doc/BRIEF.md
# Single-Channel DMA Register Set and Handshake Engine

This block is one channel of a classic byte-port DMA controller. Software programs it through an 8-bit I/O write port. The 16-bit start address and 16-bit byte count are loaded a byte at a time. A pointer bit, shared by both, chooses low or high byte and is cleared by a dedicated port. An 8-bit page register fills in physical address bits 23:16. A mode register sets the direction, auto-initialise and address stepping. A mask bit gates the channel.

Once unmasked, the channel serves one peripheral with a request/acknowledge handshake. Each request moves one byte. While the acknowledge is high, the block drives a memory read or memory write strobe along with the 24-bit address. On the last byte the channel raises terminal count. It then either reloads its start values (auto-initialise) or masks itself.

Top module: `dma_chan_regs`

## Requirements
- R1: After a synchronous active-low reset the channel is masked, the byte pointer selects the low byte, and dack, mem_rd, mem_wr and tc are all 0. A dreq asserted in this state produces no dack.
- R2: A write of any value to port 0x0C points the shared byte pointer at the low byte. Each write to port 0x04 (address) or 0x05 (count) loads the byte the pointer selects, low byte first, and then flips the pointer.
- R3: A write to port 0x0A whose bits 1:0 equal the channel number (default 2) sets the mask when bit 2 is 1 and clears it when bit 2 is 0. The same write naming another channel leaves the mask unchanged.
- R4: A write to port 0x0B whose bits 1:0 equal the channel number stores bits 7:2: bits 3:2 direction, bit 4 auto-initialise, bit 5 address decrement. The same write naming another channel is ignored.
- R5: Port 0x81 loads mem_addr[23:16]. It stays fixed while the 16-bit address steps, including when the address wraps through 0xFFFF/0x0000.
- R6: When the channel is idle and unmasked, a dreq sampled high gives dack high for exactly the next cycle. The channel then starts no further byte until dreq has been seen low.
- R7: During dack, direction 01 (peripheral to memory) asserts mem_wr and direction 10 (memory to peripheral) asserts mem_rd. Direction 00 asserts neither strobe. No strobe is ever asserted without dack.
- R8: After each byte the current address steps by +1, or by -1 when mode bit 5 is set. mem_addr[15:0] shows the current address.
- R9: A programmed count N moves N+1 bytes. tc is high together with dack on the byte taken when the current count is 0, and only then.
- R10: Without auto-initialise, terminal count sets the mask, and later dreq pulses produce no dack.
- R11: With auto-initialise, terminal count reloads the current address and count from the last programmed values, and the channel stays unmasked.
- R12: Address and count writes update both the stored start value and the current value, even while the channel is unmasked. If a register write and a transfer step fall in the same cycle, the write takes precedence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_addr | input | 8 | I/O port number |
| io_wdata | input | 8 | I/O write data |
| dreq | input | 1 | Peripheral transfer request |
| dack | output | 1 | Acknowledge to the peripheral, one cycle per byte |
| mem_rd | output | 1 | Memory read strobe (memory to peripheral) |
| mem_wr | output | 1 | Memory write strobe (peripheral to memory) |
| mem_addr | output | 24 | Physical address: page byte over current address |
| tc | output | 1 | Terminal count, on the final byte |

## Verification
If the byte pointer is wrong, a later address or count lands with its bytes swapped. That shows as a wrong mem_addr on the first acknowledged byte after programming. A count or reload fault moves tc to the wrong byte, or shows on the first byte after the wrap as a mem_addr that is not the start value. A stuck mask or a lost release of dreq shows within one cycle as a dack that should, or should not, be there. The bench holds a behavioural model and compares every output port each clock, so any such divergence shows up in the cycle it occurs.

// File: rtl/dma_chan_pkg.sv
// Shared types for the single DMA channel.
// Assumes a byte-wide I/O port; the mode fields sit in bits 7:2 of a mode write.
package dma_chan_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        DIR_VERIFY   = 2'b00,
        DIR_TO_MEM   = 2'b01,
        DIR_FROM_MEM = 2'b10,
        DIR_RSVD     = 2'b11
    } xfer_dir_e;

    // Packed in the same order as mode-write bits 7:2
    typedef struct packed {
        logic [1:0] kind;
        logic       down;
        logic       auto_init;
        xfer_dir_e  dir;
    } chan_mode_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_MOVE = 2'b01,
        ST_HOLD = 2'b10
    } xfer_state_e;

endpackage

// File: rtl/dma_port_decode.sv
// I/O write decoder for one DMA channel: shared byte pointer, mask bit,
// mode and page registers, and the byte-load strobes for the two word registers.
// Assumes one io_wr pulse per write. A mask write wins over set_mask in the same cycle.
module dma_port_decode
    import dma_chan_pkg::*;
#(
    parameter logic [1:0] CHAN       = 2'd2,
    parameter int         IO_AW      = 8,
    parameter int         PORT_ADDR  = 'h04,
    parameter int         PORT_CNT   = 'h05,
    parameter int         PORT_MASK  = 'h0A,
    parameter int         PORT_MODE  = 'h0B,
    parameter int         PORT_CLRFF = 'h0C,
    parameter int         PORT_PAGE  = 'h81
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic [BYTE_W-1:0] io_wdata,
    input  logic              set_mask,
    output logic              masked,
    output chan_mode_t        mode,
    output logic [BYTE_W-1:0] page,
    output logic              addr_wr_lo,
    output logic              addr_wr_hi,
    output logic              cnt_wr_lo,
    output logic              cnt_wr_hi
);

    logic hi_sel;
    logic hit_addr, hit_cnt, hit_mask, hit_mode, hit_clr, hit_page;
    logic own_chan;

    // Port match decode
    always_comb begin
        hit_addr = io_wr && (io_addr == IO_AW'(PORT_ADDR));
        hit_cnt  = io_wr && (io_addr == IO_AW'(PORT_CNT));
        hit_mask = io_wr && (io_addr == IO_AW'(PORT_MASK));
        hit_mode = io_wr && (io_addr == IO_AW'(PORT_MODE));
        hit_clr  = io_wr && (io_addr == IO_AW'(PORT_CLRFF));
        hit_page = io_wr && (io_addr == IO_AW'(PORT_PAGE));
        own_chan = (io_wdata[1:0] == CHAN);
    end

    // Byte-load strobes steered by the shared pointer
    always_comb begin
        addr_wr_lo = hit_addr && !hi_sel;
        addr_wr_hi = hit_addr &&  hi_sel;
        cnt_wr_lo  = hit_cnt  && !hi_sel;
        cnt_wr_hi  = hit_cnt  &&  hi_sel;
    end

    // Shared low/high byte pointer
    always_ff @(posedge clk) begin
        if (!rst_n)                  hi_sel <= 1'b0;
        else if (hit_clr)            hi_sel <= 1'b0;
        else if (hit_addr || hit_cnt) hi_sel <= !hi_sel;
    end

    // Channel mask: software write first, then self-mask at terminal count
    always_ff @(posedge clk) begin
        if (!rst_n)                     masked <= 1'b1;
        else if (hit_mask && own_chan)  masked <= io_wdata[2];
        else if (set_mask)              masked <= 1'b1;
    end

    // Mode register, loaded only by writes that name this channel
    always_ff @(posedge clk) begin
        if (!rst_n)                    mode <= '0;
        else if (hit_mode && own_chan) mode <= chan_mode_t'(io_wdata[7:2]);
    end

    // Page register supplying the upper address byte
    always_ff @(posedge clk) begin
        if (!rst_n)        page <= '0;
        else if (hit_page) page <= io_wdata;
    end

    p_pointer_flips_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_addr || hit_cnt) |=> (hi_sel != $past(hi_sel)));
    p_clear_pointer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit_clr |=> !hi_sel);
    p_foreign_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_mask && !own_chan && !set_mask) |=> $stable(masked));

endmodule

// File: rtl/dma_word_reg.sv
// Base/current register pair of two bytes, loaded a byte at a time.
// A byte write updates base and current together and beats reload or step.
// Reload copies base into current; step moves current by one, up or down.
module dma_word_reg
    import dma_chan_pkg::*;
#(
    parameter int W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              step,
    input  logic              down,
    input  logic              reload,
    output logic [W-1:0]      cur
);

    localparam int HI_W = W - BYTE_W;

    logic [W-1:0] base;

    // Start value, written only by software
    always_ff @(posedge clk) begin
        if (!rst_n)     base <= '0;
        else if (wr_lo) base <= {base[W-1:BYTE_W], wdata};
        else if (wr_hi) base <= {wdata[HI_W-1:0], base[BYTE_W-1:0]};
    end

    // Working value: write, then reload, then step
    always_ff @(posedge clk) begin
        if (!rst_n)      cur <= '0;
        else if (wr_lo)  cur <= {cur[W-1:BYTE_W], wdata};
        else if (wr_hi)  cur <= {wdata[HI_W-1:0], cur[BYTE_W-1:0]};
        else if (reload) cur <= base;
        else if (step)   cur <= down ? cur - W'(1) : cur + W'(1);
    end

    p_reload_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && !wr_lo && !wr_hi) |=> (cur == $past(base)));
    p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !reload && !wr_lo && !wr_hi) |=>
        (cur == ($past(down) ? $past(cur) - W'(1) : $past(cur) + W'(1))));
    p_write_both_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (cur[BYTE_W-1:0] == base[BYTE_W-1:0]));

endmodule

// File: rtl/dma_xfer_ctrl.sv
// Single-transfer handshake engine: one byte per dreq assertion.
// Idle -> Move (dack for one cycle) -> Hold until dreq is low -> Idle.
// Assumes dreq is synchronous to clk.
module dma_xfer_ctrl
    import dma_chan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dreq,
    input  logic       masked,
    input  logic       cnt_zero,
    input  chan_mode_t mode,
    output logic       dack,
    output logic       mem_rd,
    output logic       mem_wr,
    output logic       tc,
    output logic       step,
    output logic       reload,
    output logic       set_mask
);

    xfer_state_e state;

    // Handshake sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: if (dreq && !masked) state <= ST_MOVE;
                ST_MOVE: state <= ST_HOLD;
                ST_HOLD: if (!dreq) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Per-byte outputs decoded from the move state
    always_comb begin
        dack     = (state == ST_MOVE);
        mem_wr   = dack && (mode.dir == DIR_TO_MEM);
        mem_rd   = dack && (mode.dir == DIR_FROM_MEM);
        tc       = dack && cnt_zero;
        step     = dack;
        reload   = tc && mode.auto_init;
        set_mask = tc && !mode.auto_init;
    end

    p_one_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dack |=> !dack);
    p_start_unmasked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (masked && !dack) |=> !dack);
    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, mem_wr}));
    p_strobe_in_dack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> dack);
    p_tc_in_dack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> dack);

endmodule

// File: rtl/dma_chan_regs.sv
// Top of one DMA channel: port decoder, address and count word registers,
// and the handshake engine. mem_addr is the page byte over the current address.
// Assumes the I/O interface and the peripheral are synchronous to clk.
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter logic [1:0] CHAN       = 2'd2,
    parameter int         IO_AW      = 8,
    parameter int         PORT_ADDR  = 'h04,
    parameter int         PORT_CNT   = 'h05,
    parameter int         PORT_MASK  = 'h0A,
    parameter int         PORT_MODE  = 'h0B,
    parameter int         PORT_CLRFF = 'h0C,
    parameter int         PORT_PAGE  = 'h81
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                io_wr,
    input  logic [IO_AW-1:0]    io_addr,
    input  logic [BYTE_W-1:0]   io_wdata,
    input  logic                dreq,
    output logic                dack,
    output logic                mem_rd,
    output logic                mem_wr,
    output logic [3*BYTE_W-1:0] mem_addr,
    output logic                tc
);

    localparam int WORD_W = 2 * BYTE_W;

    logic              masked, set_mask, step, reload;
    logic              addr_wr_lo, addr_wr_hi, cnt_wr_lo, cnt_wr_hi;
    chan_mode_t        mode;
    logic [BYTE_W-1:0] page;
    logic [WORD_W-1:0] cur_addr, cur_cnt;

    dma_port_decode #(
        .CHAN(CHAN), .IO_AW(IO_AW), .PORT_ADDR(PORT_ADDR), .PORT_CNT(PORT_CNT),
        .PORT_MASK(PORT_MASK), .PORT_MODE(PORT_MODE), .PORT_CLRFF(PORT_CLRFF),
        .PORT_PAGE(PORT_PAGE)
    ) i_decode (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
        .io_wdata(io_wdata), .set_mask(set_mask), .masked(masked), .mode(mode),
        .page(page), .addr_wr_lo(addr_wr_lo), .addr_wr_hi(addr_wr_hi),
        .cnt_wr_lo(cnt_wr_lo), .cnt_wr_hi(cnt_wr_hi)
    );

    dma_word_reg #(.W(WORD_W)) i_addr_reg (
        .clk(clk), .rst_n(rst_n), .wr_lo(addr_wr_lo), .wr_hi(addr_wr_hi),
        .wdata(io_wdata), .step(step), .down(mode.down), .reload(reload),
        .cur(cur_addr)
    );

    dma_word_reg #(.W(WORD_W)) i_cnt_reg (
        .clk(clk), .rst_n(rst_n), .wr_lo(cnt_wr_lo), .wr_hi(cnt_wr_hi),
        .wdata(io_wdata), .step(step), .down(1'b1), .reload(reload),
        .cur(cur_cnt)
    );

    dma_xfer_ctrl i_ctrl (
        .clk(clk), .rst_n(rst_n), .dreq(dreq), .masked(masked),
        .cnt_zero(cur_cnt == '0), .mode(mode), .dack(dack), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .tc(tc), .step(step), .reload(reload),
        .set_mask(set_mask)
    );

    // Physical address presented with each byte
    always_comb mem_addr = {page, cur_addr};

    p_tc_masks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tc && !mode.auto_init && !(io_wr && io_addr == IO_AW'(PORT_MASK))) |=> masked);
    p_auto_stays_open_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tc && mode.auto_init && !(io_wr && io_addr == IO_AW'(PORT_MASK))) |=> !masked);
    p_page_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dack && !io_wr) |=> $stable(mem_addr[3*BYTE_W-1:WORD_W]));

endmodule

// File: tb/test_dma_chan_regs.sv
module test_dma_chan_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        dreq = 1'b0;
    logic        dack, mem_rd, mem_wr, tc;
    logic [23:0] mem_addr;

    int n_chk = 0;
    int n_fail = 0;
    bit chk_on = 1'b0;
    bit done = 1'b0;

    always #10 clk = !clk;

    dma_chan_regs i_dma_chan_regs (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
        .io_wdata(io_wdata), .dreq(dreq), .dack(dack), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_addr(mem_addr), .tc(tc)
    );

    // Behavioural reference model
    int        m_st;
    bit        m_mask, m_ff, m_auto, m_down;
    int        m_dir;
    logic [7:0]  m_page;
    logic [15:0] m_bA, m_cA, m_bC, m_cC;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_mask = 1; m_ff = 0; m_auto = 0; m_down = 0; m_dir = 0;
            m_page = 0; m_bA = 0; m_cA = 0; m_bC = 0; m_cC = 0;
        end else begin
            int nst;
            nst = m_st;
            if (m_st == 0 && dreq && !m_mask) nst = 1;
            else if (m_st == 1) nst = 2;
            else if (m_st == 2 && !dreq) nst = 0;
            if (m_st == 1) begin
                if (m_cC == 0 && m_auto) begin
                    m_cA = m_bA; m_cC = m_bC;
                end else begin
                    if (m_cC == 0) m_mask = 1;
                    m_cA = m_down ? m_cA - 16'd1 : m_cA + 16'd1;
                    m_cC = m_cC - 16'd1;
                end
            end
            if (io_wr) begin
                case (io_addr)
                    8'h0C: m_ff = 0;
                    8'h04: begin
                        if (m_ff) begin m_bA[15:8] = io_wdata; m_cA[15:8] = io_wdata; end
                        else      begin m_bA[7:0]  = io_wdata; m_cA[7:0]  = io_wdata; end
                        m_ff = !m_ff;
                    end
                    8'h05: begin
                        if (m_ff) begin m_bC[15:8] = io_wdata; m_cC[15:8] = io_wdata; end
                        else      begin m_bC[7:0]  = io_wdata; m_cC[7:0]  = io_wdata; end
                        m_ff = !m_ff;
                    end
                    8'h0A: if (io_wdata[1:0] == 2) m_mask = io_wdata[2];
                    8'h0B: if (io_wdata[1:0] == 2) begin
                        m_dir = io_wdata[3:2]; m_auto = io_wdata[4]; m_down = io_wdata[5];
                    end
                    8'h81: m_page = io_wdata;
                    default: ;
                endcase
            end
            m_st = nst;
        end
    end

    task automatic check(input string tag, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (chk_on && !done) begin
            check("R6", "dack vs model", dack, m_st == 1);
            check("R7", "mem_wr vs model", mem_wr, m_st == 1 && m_dir == 1);
            check("R7", "mem_rd vs model", mem_rd, m_st == 1 && m_dir == 2);
            check("R9", "tc vs model", tc, m_st == 1 && m_cC == 0);
            check("R5", "mem_addr vs model", mem_addr, {m_page, m_cA});
        end
    end

    task automatic io_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    // One dreq pulse with directed expectations on the acknowledged cycle
    task automatic byte_xfer(input string tag, input logic e_dack, input logic [23:0] e_addr,
                             input logic e_wr, input logic e_rd, input logic e_tc);
        @(negedge clk);
        dreq = 1'b1;
        @(negedge clk);
        check(tag, "dack", dack, e_dack);
        if (e_dack) begin
            check(tag, "mem_addr", mem_addr, e_addr);
            check(tag, "mem_wr", mem_wr, e_wr);
            check(tag, "mem_rd", mem_rd, e_rd);
            check(tag, "tc", tc, e_tc);
        end
        dreq = 1'b0;
        @(negedge clk);
        check(tag, "dack released", dack, 1'b0);
        @(negedge clk);
    endtask

    initial begin
        #(20 * 190000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        chk_on = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1", "dack after reset", dack, 1'b0);
        check("R1", "tc after reset", tc, 1'b0);
        check("R1", "strobes after reset", {mem_rd, mem_wr}, 2'b00);
        byte_xfer("R1", 1'b0, 24'h0, 1'b0, 1'b0, 1'b0);

        // Program auto-init, increment, to-memory, count 2, address 0x1234, page 0x5A
        io_write(8'h0C, 8'hA5);
        io_write(8'h04, 8'h34);
        io_write(8'h04, 8'h12);
        io_write(8'h05, 8'h02);
        io_write(8'h05, 8'h00);
        io_write(8'h81, 8'h5A);
        io_write(8'h0B, 8'h56);
        io_write(8'h0A, 8'h06);
        byte_xfer("R3", 1'b0, 24'h0, 1'b0, 1'b0, 1'b0);
        io_write(8'h0A, 8'h00);
        byte_xfer("R3", 1'b0, 24'h0, 1'b0, 1'b0, 1'b0);
        io_write(8'h0A, 8'h02);

        byte_xfer("R7", 1'b1, 24'h5A1234, 1'b1, 1'b0, 1'b0);
        byte_xfer("R8", 1'b1, 24'h5A1235, 1'b1, 1'b0, 1'b0);
        byte_xfer("R9", 1'b1, 24'h5A1236, 1'b1, 1'b0, 1'b1);
        byte_xfer("R11", 1'b1, 24'h5A1234, 1'b1, 1'b0, 1'b0);
        byte_xfer("R11", 1'b1, 24'h5A1235, 1'b1, 1'b0, 1'b0);
        byte_xfer("R9", 1'b1, 24'h5A1236, 1'b1, 1'b0, 1'b1);

        // R4: mode write naming channel 1 is ignored
        io_write(8'h0B, 8'h59);
        byte_xfer("R4", 1'b1, 24'h5A1234, 1'b1, 1'b0, 1'b0);

        // R2: stray byte, pointer clear, then decrement / no-auto / from-memory
        io_write(8'h0A, 8'h06);
        io_write(8'h04, 8'h77);
        io_write(8'h0C, 8'h00);
        io_write(8'h04, 8'h00);
        io_write(8'h04, 8'h01);
        io_write(8'h05, 8'h01);
        io_write(8'h05, 8'h00);
        io_write(8'h81, 8'h03);
        io_write(8'h0B, 8'h6A);
        io_write(8'h0A, 8'h02);
        byte_xfer("R2", 1'b1, 24'h030100, 1'b0, 1'b1, 1'b0);
        byte_xfer("R8", 1'b1, 24'h0300FF, 1'b0, 1'b1, 1'b1);
        byte_xfer("R10", 1'b0, 24'h0, 1'b0, 1'b0, 1'b0);

        // R5: wrap of the low 16 bits leaves the page alone
        io_write(8'h0C, 8'h00);
        io_write(8'h04, 8'hFF);
        io_write(8'h04, 8'hFF);
        io_write(8'h05, 8'h01);
        io_write(8'h05, 8'h00);
        io_write(8'h0B, 8'h4A);
        io_write(8'h0A, 8'h02);
        byte_xfer("R5", 1'b1, 24'h03FFFF, 1'b0, 1'b1, 1'b0);
        byte_xfer("R5", 1'b1, 24'h030000, 1'b0, 1'b1, 1'b1);
        byte_xfer("R10", 1'b0, 24'h0, 1'b0, 1'b0, 1'b0);

        // R7 verify type, then R12 address rewrite while unmasked
        io_write(8'h0C, 8'h00);
        io_write(8'h04, 8'h00);
        io_write(8'h04, 8'h40);
        io_write(8'h05, 8'h05);
        io_write(8'h05, 8'h00);
        io_write(8'h0B, 8'h52);
        io_write(8'h0A, 8'h02);
        byte_xfer("R7", 1'b1, 24'h034000, 1'b0, 1'b0, 1'b0);
        io_write(8'h04, 8'h00);
        io_write(8'h04, 8'h50);
        byte_xfer("R12", 1'b1, 24'h035000, 1'b0, 1'b0, 1'b0);

        // R6: dreq held high gives exactly one byte
        @(negedge clk);
        dreq = 1'b1;
        @(negedge clk);
        check("R6", "first dack", dack, 1'b1);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R6", "no second dack while dreq held", dack, 1'b0);
        end
        dreq = 1'b0;
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule